// File: doc/BRIEF.md
# Paged Memory Window Interface

This block places an 8192-byte memory behind a bus window of 64 addresses. When address bit 5 is low, the five low address bits select one byte within a 32-byte slice of the memory. The slice is chosen by an 8-bit page register, which picks one of 256 pages. When address bit 5 is high, the access reaches the page register itself, whatever the other five bits hold. The block builds the 13-bit memory address from the page value and the low address bits. It samples the active-low read and write strobes, commits each write once the write strobe returns high, and enables its read data only while a read is in progress.

The strobes are sampled in the block's clock domain through a short chain of flops, and the chain depth is a parameter. A write is committed in the cycle after the sampled strobe is seen rising, using the address and data captured while the strobe was low. A low standby input or an active power-fail input blocks every access. A second select input routes accesses to a neighbouring clock port, and the memory select takes priority over it. The memory cells are outside the block: the block drives their address, write data and write enable, and it takes their read data back.

Top module: `mwin_paged_port`

## Requirements
- R1: After reset the page register holds 0x00, the read-data enable is low and no memory write is issued.
- R2: A read with the memory select low, read strobe low and address bit 5 low returns the memory byte at address {page, A4..A0}. The page occupies memory address bits 12:5 and A4..A0 occupy bits 4:0.
- R3: A read with address bit 5 high returns the full 8-bit page register for every value of A4..A0, so there are 32 aliases at window addresses 0x20 to 0x3F.
- R4: A write to any window address with bit 5 high loads the page register. Later slice accesses use the new page.
- R5: A write takes effect only after the write strobe rises. While the strobe stays low, neither the page nor the memory changes. Each low-then-high strobe pulse produces exactly one memory write pulse.
- R6: The read-data enable is high only while the memory select is low, the read strobe is low, standby is high and power-fail is low.
- R7: A write made while standby is low or power-fail is high leaves the page register and the memory unchanged.
- R8: When the memory select and the clock-port select are both low, the access goes to the memory and the clock-port route output stays low. The clock-port select alone drives that output high.
- R9: A write with address bit 5 low stores the data byte at memory address {page, A4..A0} and does not alter the page register.
- R10: A write strobe pulse with the memory select high changes neither the page register nor the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_sel_n | input | 1 | Memory window select, active low |
| clk_sel_n | input | 1 | Clock-port select, active low |
| addr | input | 6 | Window address; bit 5 selects the page register |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; commits on its rise |
| wdata | input | 8 | Write data from the bus |
| stby_n | input | 1 | Standby, active low; blocks access |
| pwr_fail | input | 1 | Power-fail indication; blocks access |
| mem_rdata | input | 8 | Read data from the memory cells |
| rdata | output | 8 | Read data to the bus |
| rdata_oe | output | 1 | Bus drive enable for rdata (high-impedance when low) |
| clk_route | output | 1 | Access routed to the clock port |
| mem_addr | output | 13 | Memory byte address {page, A4..A0} |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | One-cycle memory write enable |

## Verification
A wrong page value shows up on the very next slice read, because the byte comes back from the wrong 32-byte slice. A read of any alias at 0x20 to 0x3F shows the same fault directly during the read, with no added delay. A broken strobe edge detector shows at the memory side within a few cycles of the strobe rising, either as a missing write pulse or as a doubled one. A broken standby or select qualifier leaves a page change that the next alias read exposes.

// File: rtl/mwin_pkg.sv
package mwin_pkg;

   localparam int unsigned WIN_AW_DEF  = 6;
   localparam int unsigned PAGE_W_DEF  = 8;
   localparam int unsigned DATA_W_DEF  = 8;
   localparam int unsigned SYNC_DEF    = 2;

   typedef enum logic {
      TGT_SLICE = 1'b0,
      TGT_PAGE  = 1'b1
   } tgt_e;

endpackage

// File: rtl/mwin_strobe_sync.sv
module mwin_strobe_sync #(
   parameter int unsigned AW         = 6,
   parameter int unsigned DW         = 8,
   parameter int unsigned SYNC_DEPTH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_act_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] data_i,
   input  logic          ok_i,
   output logic          commit_o,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] data_o
);

   localparam int unsigned STAGES = SYNC_DEPTH + 1;
   localparam int unsigned LAST   = STAGES - 1;

   generate
      if (SYNC_DEPTH < 1) begin : g_bad_depth
         $error("mwin_strobe_sync: SYNC_DEPTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0]         act_q;
   logic [STAGES-1:0][AW-1:0] addr_q;
   logic [STAGES-1:0][DW-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= '0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         act_q[0]  <= wr_act_i;
         addr_q[0] <= addr_i;
         data_q[0] <= data_i;
         for (int s = 1; s < STAGES; s++) begin
            act_q[s]  <= act_q[s-1];
            addr_q[s] <= addr_q[s-1];
            data_q[s] <= data_q[s-1];
         end
      end
   end

   // rising edge of the sampled strobe: older stage active, newer stage idle
   assign commit_o = act_q[LAST] & ~act_q[LAST-1] & ok_i;
   assign addr_o   = addr_q[LAST];
   assign data_o   = data_q[LAST];

endmodule

// File: rtl/mwin_page_reg.sv
module mwin_page_reg #(
   parameter int unsigned PW = 8,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [DW-1:0] data_i,
   input  logic          ok_i,
   output logic [PW-1:0] page_o
);

   generate
      if (PW > DW) begin : g_bad_width
         $error("mwin_page_reg: page wider than the data bus");
      end
   endgenerate

   logic [PW-1:0] page_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) page_q <= '0;
      else if (load_i) page_q <= data_i[PW-1:0];
   end

   assign page_o = page_q;

   // R7: no page change in the cycle after access was blocked
   a_r7_page_hold_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      !ok_i |=> $stable(page_q));

endmodule

// File: rtl/mwin_decode.sv
module mwin_decode
   import mwin_pkg::*;
#(
   parameter int unsigned AW = 6,
   parameter int unsigned PW = 8,
   parameter int unsigned DW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr_i,
   input  logic             mem_sel_n_i,
   input  logic             clk_sel_n_i,
   input  logic             rd_n_i,
   input  logic             ok_i,
   input  logic [PW-1:0]    page_i,
   input  logic [DW-1:0]    mem_rdata_i,
   input  logic             commit_i,
   input  logic [AW-1:0]    cap_addr_i,
   input  logic [DW-1:0]    cap_data_i,
   output logic             page_load_o,
   output logic [PW+AW-2:0] mem_addr_o,
   output logic             mem_we_o,
   output logic [DW-1:0]    mem_wdata_o,
   output logic [DW-1:0]    rdata_o,
   output logic             rdata_oe_o,
   output logic             clk_route_o
);

   localparam int unsigned SW = AW - 1;

   tgt_e live_tgt, cap_tgt;
   logic [SW-1:0] slice_idx;

   assign live_tgt = addr_i[AW-1]     ? TGT_PAGE : TGT_SLICE;
   assign cap_tgt  = cap_addr_i[AW-1] ? TGT_PAGE : TGT_SLICE;

   assign page_load_o = commit_i && (cap_tgt == TGT_PAGE);
   assign mem_we_o    = commit_i && (cap_tgt == TGT_SLICE);
   assign mem_wdata_o = cap_data_i;

   assign slice_idx  = commit_i ? cap_addr_i[SW-1:0] : addr_i[SW-1:0];
   assign mem_addr_o = {page_i, slice_idx};

   logic [DW-1:0] page_ext;
   always_comb begin
      page_ext = '0;
      page_ext[PW-1:0] = page_i;
   end

   assign rdata_oe_o  = ~mem_sel_n_i & ~rd_n_i & ok_i;
   assign rdata_o     = !rdata_oe_o ? '0 :
                        (live_tgt == TGT_PAGE) ? page_ext : mem_rdata_i;
   // memory select takes priority over the clock-port select
   assign clk_route_o = ~clk_sel_n_i & mem_sel_n_i & ok_i;

   // R8: clock-port route never coexists with an active memory select
   a_r8_mem_over_clk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_sel_n_i |-> !clk_route_o);

endmodule

// File: rtl/mwin_paged_port.sv
module mwin_paged_port
   import mwin_pkg::*;
#(
   parameter int unsigned WIN_AW     = WIN_AW_DEF,
   parameter int unsigned PAGE_W     = PAGE_W_DEF,
   parameter int unsigned DATA_W     = DATA_W_DEF,
   parameter int unsigned SYNC_DEPTH = SYNC_DEF,
   localparam int unsigned MEM_AW    = PAGE_W + WIN_AW - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_sel_n,
   input  logic              clk_sel_n,
   input  logic [WIN_AW-1:0] addr,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] wdata,
   input  logic              stby_n,
   input  logic              pwr_fail,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe,
   output logic              clk_route,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we
);

   generate
      if (WIN_AW < 2) begin : g_bad_win
         $error("mwin_paged_port: window needs at least two address bits");
      end
      if (PAGE_W > DATA_W) begin : g_bad_page
         $error("mwin_paged_port: page register cannot exceed data width");
      end
   endgenerate

   logic              ok_live;
   logic              wr_act;
   logic              commit;
   logic              page_load;
   logic [WIN_AW-1:0] cap_addr;
   logic [DATA_W-1:0] cap_data;
   logic [PAGE_W-1:0] page;

   assign ok_live = stby_n & ~pwr_fail;
   assign wr_act  = ~wr_n & ~mem_sel_n & ok_live;

   mwin_strobe_sync #(
      .AW(WIN_AW), .DW(DATA_W), .SYNC_DEPTH(SYNC_DEPTH)
   ) u_sync (
      .clk(clk), .rst_n(rst_n),
      .wr_act_i(wr_act), .addr_i(addr), .data_i(wdata), .ok_i(ok_live),
      .commit_o(commit), .addr_o(cap_addr), .data_o(cap_data)
   );

   mwin_page_reg #(
      .PW(PAGE_W), .DW(DATA_W)
   ) u_page (
      .clk(clk), .rst_n(rst_n),
      .load_i(page_load), .data_i(cap_data), .ok_i(ok_live),
      .page_o(page)
   );

   mwin_decode #(
      .AW(WIN_AW), .PW(PAGE_W), .DW(DATA_W)
   ) u_dec (
      .clk(clk), .rst_n(rst_n),
      .addr_i(addr), .mem_sel_n_i(mem_sel_n), .clk_sel_n_i(clk_sel_n),
      .rd_n_i(rd_n), .ok_i(ok_live), .page_i(page), .mem_rdata_i(mem_rdata),
      .commit_i(commit), .cap_addr_i(cap_addr), .cap_data_i(cap_data),
      .page_load_o(page_load), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
      .mem_wdata_o(mem_wdata), .rdata_o(rdata), .rdata_oe_o(rdata_oe),
      .clk_route_o(clk_route)
   );

   // R5: each strobe rise yields a single one-cycle write pulse
   a_r5_single_we: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   // R6: read drive only during an enabled read
   a_r6_oe_gated: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> (stby_n && !pwr_fail && !rd_n && !mem_sel_n));

   // R9: a memory write never coincides with a page update
   a_r9_we_excl_page: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !page_load);

   // R1: reset leaves the bus undriven until a read strobe arrives
   a_r1_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
      rd_n |-> !rdata_oe);

endmodule

// File: tb/tb_mwin_paged_port.sv
module tb_mwin_paged_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_sel_n = 1'b1;
   logic        clk_sel_n = 1'b1;
   logic [5:0]  addr = '0;
   logic        rd_n = 1'b1;
   logic        wr_n = 1'b1;
   logic [7:0]  wdata = '0;
   logic        stby_n = 1'b1;
   logic        pwr_fail = 1'b0;
   logic [7:0]  mem_rdata;
   logic [7:0]  rdata;
   logic        rdata_oe;
   logic        clk_route;
   logic [12:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        mem_we;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   mwin_paged_port dut (
      .clk(clk), .rst_n(rst_n), .mem_sel_n(mem_sel_n), .clk_sel_n(clk_sel_n),
      .addr(addr), .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata), .stby_n(stby_n),
      .pwr_fail(pwr_fail), .mem_rdata(mem_rdata), .rdata(rdata),
      .rdata_oe(rdata_oe), .clk_route(clk_route), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_we(mem_we)
   );

   // memory cell model: untouched bytes hold a computed pattern
   logic [7:0] cells [int];
   int we_count = 0;
   int epoch = 0;

   function automatic logic [7:0] seed(input int a);
      return 8'((a * 7 + 3) & 255);
   endfunction

   function automatic logic [7:0] cell_rd(input logic [12:0] a, input int ep);
      if (ep >= 0 && cells.exists(int'(a))) return cells[int'(a)];
      return seed(int'(a));
   endfunction

   always_comb mem_rdata = cell_rd(mem_addr, epoch);

   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         cells[int'(mem_addr)] = mem_wdata;
         we_count = we_count + 1;
         epoch = epoch + 1;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      mem_sel_n = 1'b0; addr = a; wdata = d; wr_n = 1'b0;
      repeat (3) @(negedge clk);
      wr_n = 1'b1;
      repeat (6) @(negedge clk);
      mem_sel_n = 1'b1;
   endtask

   task automatic bus_read(input logic [5:0] a, output logic [7:0] d);
      @(negedge clk);
      mem_sel_n = 1'b0; addr = a; rd_n = 1'b0;
      #2;
      d = rdata;
      @(negedge clk);
      rd_n = 1'b1; mem_sel_n = 1'b1;
   endtask

   typedef struct packed {
      logic       is_wr;
      logic [5:0] a;
      logic [7:0] d;
      logic [7:0] req;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 6'h20, 8'h05, 8'd4},   // R4 page=5 via base alias
      '{1'b0, 6'h3F, 8'h05, 8'd3},   // R3 top alias reads page
      '{1'b1, 6'h03, 8'hA1, 8'd9},   // R9 store at 5*32+3
      '{1'b0, 6'h03, 8'hA1, 8'd2},   // R2 read back
      '{1'b0, 6'h04, 8'h7F, 8'd2},   // R2 seed(164)
      '{1'b1, 6'h2A, 8'hFF, 8'd4},   // R4 page=FF via mid alias
      '{1'b0, 6'h21, 8'hFF, 8'd3},   // R3 alias reads full 8 bits
      '{1'b0, 6'h03, 8'h38, 8'd2},   // R2 seed(8163)
      '{1'b1, 6'h1F, 8'h3C, 8'd9},   // R9 top byte 8191
      '{1'b0, 6'h1F, 8'h3C, 8'd2},   // R2 read top byte
      '{1'b1, 6'h35, 8'h05, 8'd4},   // R4 back to page 5
      '{1'b0, 6'h03, 8'hA1, 8'd2}    // R2 earlier byte still there
   };

   initial begin : main
      logic [7:0] rv;
      int wc;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 oe", int'(rdata_oe), 0);
      chk("R1 we", int'(mem_we), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      bus_read(6'h20, rv);
      chk("R1 page", int'(rv), 8'h00);
      chk("R1 no writes", we_count, 0);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].is_wr) begin
            bus_write(VECS[i].a, VECS[i].d);
         end else begin
            bus_read(VECS[i].a, rv);
            chk($sformatf("R%0d vec%0d", VECS[i].req, i), int'(rv), int'(VECS[i].d));
         end
      end

      // R5: strobe held low has no effect until it rises
      wc = we_count;
      @(negedge clk);
      mem_sel_n = 1'b0; addr = 6'h07; wdata = 8'h99; wr_n = 1'b0; rd_n = 1'b0;
      repeat (8) @(negedge clk);
      chk("R5 no we while low", we_count - wc, 0);
      addr = 6'h22; #2;
      chk("R5 page held", int'(rdata), 8'h05);
      addr = 6'h07; rd_n = 1'b1;
      @(negedge clk);
      wr_n = 1'b1;
      repeat (6) @(negedge clk);
      mem_sel_n = 1'b1;
      chk("R5 one pulse", we_count - wc, 1);
      bus_read(6'h07, rv);
      chk("R5 data", int'(rv), 8'h99);

      // R6: read enable gating
      @(negedge clk);
      mem_sel_n = 1'b1; rd_n = 1'b0; #2;
      chk("R6 unselected", int'(rdata_oe), 0);
      mem_sel_n = 1'b0; rd_n = 1'b1; #2;
      chk("R6 no strobe", int'(rdata_oe), 0);
      rd_n = 1'b0; stby_n = 1'b0; #2;
      chk("R6 standby", int'(rdata_oe), 0);
      stby_n = 1'b1; pwr_fail = 1'b1; #2;
      chk("R6 power fail", int'(rdata_oe), 0);
      pwr_fail = 1'b0; #2;
      chk("R6 enabled", int'(rdata_oe), 1);
      rd_n = 1'b1; mem_sel_n = 1'b1;

      // R7: blocked writes
      wc = we_count;
      stby_n = 1'b0;
      bus_write(6'h20, 8'h66);
      bus_write(6'h07, 8'h11);
      stby_n = 1'b1;
      pwr_fail = 1'b1;
      bus_write(6'h3C, 8'h77);
      pwr_fail = 1'b0;
      repeat (2) @(negedge clk);
      bus_read(6'h20, rv);
      chk("R7 page unchanged", int'(rv), 8'h05);
      chk("R7 no we", we_count - wc, 0);
      bus_read(6'h07, rv);
      chk("R7 memory unchanged", int'(rv), 8'h99);

      // R8: select priority
      @(negedge clk);
      clk_sel_n = 1'b0; #2;
      chk("R8 clock alone", int'(clk_route), 1);
      mem_sel_n = 1'b0; #2;
      chk("R8 memory wins", int'(clk_route), 0);
      clk_sel_n = 1'b1; mem_sel_n = 1'b1;

      // R10: write pulse with the memory select high
      wc = we_count;
      @(negedge clk);
      addr = 6'h20; wdata = 8'h44; wr_n = 1'b0;
      repeat (3) @(negedge clk);
      wr_n = 1'b1;
      repeat (6) @(negedge clk);
      bus_read(6'h20, rv);
      chk("R10 page unchanged", int'(rv), 8'h05);
      chk("R10 no we", we_count - wc, 0);

      // R1: a second reset returns the page to zero
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      repeat (2) @(negedge clk);
      bus_read(6'h2F, rv);
      chk("R1 page after reset", int'(rv), 8'h00);

      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : watchdog
      #1000000;
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule